// File: doc/BRIEF.md
# Address-Space-Tagged Associative Translation Buffer

This block is a fully associative translation buffer. It caches mappings from virtual page numbers to physical frame numbers, and each entry carries a permission field. Every entry is tagged with an address-space number. An entry with its global bit set is shared by every address space. A lookup is purely combinational. It takes a full virtual address and the current address-space number. It returns a hit flag, the frame number, the permission bits and the composed physical address. Pages are 8 KB, so the low 13 address bits pass straight through as the page offset.

The block accepts four commands, each taking effect at a rising clock edge:
- **Insert:** writes an entry into the slot named by a rotating victim pointer.
- **Flush everything:** invalidates every entry.
- **Drop all non-global entries:** removes entries private to an address space.
- **Drop one page:** removes one page for one address space.

The walker that fills the buffer, the permission checks and the fault reporting all sit outside the block. The depth is a parameter. A typical instruction-side instance uses 48 entries and a data-side instance uses 64.

Top module: `asid_tlb`

## Requirements
- R1: `lk_hit` is 1 exactly when some entry satisfies all three conditions: it is valid, its tag equals `lk_va[VA_W-1:13]`, and either its global bit is set or its stored address-space number equals `lk_asn`.
- R2: On a hit, `lk_pfn` and `lk_perm` are the matching entry's frame and permission fields, and `lk_pa` equals `{lk_pfn, lk_va[12:0]}`. On a miss, all three outputs are zero.
- R3: An insert writes the entry into the slot at the victim pointer and marks it valid, then advances the pointer by one. The write happens even when that slot already holds a valid entry.
- R4: The victim pointer wraps from slot ENTRIES-1 back to slot 0.
- R5: Flush-all invalidates every entry and returns the victim pointer to slot 0.
- R6: Flush-local invalidates every entry whose global bit is clear. Entries with the global bit set stay valid.
- R7: Flush-page invalidates every entry that meets two conditions: its tag equals `fl_vpn`, and either its address-space number equals `fl_asn` or its global bit is set. All other entries are untouched.
- R8: When `fl_all` is high, every other command in the same cycle is ignored: no entry is written and the pointer goes to 0.
- R9: A lookup in the same cycle as any command sees the contents from before that cycle's edge.
- R10: After reset, no entry is valid and the victim pointer is at slot 0.
- R11: When several entries match a lookup, the lowest-numbered slot supplies the outputs.
- R12: When flush-local or flush-page coincides with an insert (without flush-all), the flushes act on the old contents first. The inserted entry is then written and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Current address-space number for the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number of the hitting entry |
| lk_perm | output | PERM_W | Permission bits of the hitting entry |
| lk_pa | output | PFN_W+13 | Physical address: frame number and page offset |
| ins_en | input | 1 | Insert command |
| ins_vpn | input | VA_W-13 | Page number to insert |
| ins_asn | input | ASN_W | Address-space number of the new entry |
| ins_glob | input | 1 | Global bit of the new entry |
| ins_pfn | input | PFN_W | Frame number of the new entry |
| ins_perm | input | PERM_W | Permission bits of the new entry |
| fl_all | input | 1 | Flush-all command |
| fl_proc | input | 1 | Flush-local (non-global) command |
| fl_addr | input | 1 | Flush-page command |
| fl_vpn | input | VA_W-13 | Page number for flush-page |
| fl_asn | input | ASN_W | Address-space number for flush-page |

## Verification
The assertions check the following on every cycle:
- A miss drives zero data.
- Flush-all leaves an empty table with the pointer at 0.
- An insert leaves the slot it targeted valid.
- The pointer wraps at the last slot.
- Flush-local removes every private entry and keeps every global one.

Only the bench scenarios can show the rest: the address-space and global matching rules, lowest-slot selection among duplicate tags, lookups that see the old contents during a same-cycle insert, and overwriting of the oldest slot after a full rotation. The bench covers these with a reference model under a mix of random and directed command traffic.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    // Page offset width: 8 KB pages.
    localparam int unsigned TLB_PAGE_SHIFT = 13;

    // Decoded command set for one cycle, after priority resolution.
    typedef struct packed {
        logic clear_all;
        logic drop_local;
        logic drop_page;
        logic write;
    } tlb_cmd_t;

endpackage

// File: rtl/asid_tlb_cmd.sv
module asid_tlb_cmd (
    input  logic                    fl_all,
    input  logic                    fl_proc,
    input  logic                    fl_addr,
    input  logic                    ins_en,
    output asid_tlb_pkg::tlb_cmd_t  cmd
);
    // Flush-all masks every other command; the rest may combine.
    always_comb begin
        cmd            = '0;
        cmd.clear_all  = fl_all;
        cmd.drop_local = fl_proc & ~fl_all;
        cmd.drop_page  = fl_addr & ~fl_all;
        cmd.write      = ins_en  & ~fl_all;
    end
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] vptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] vptr_d, vptr_q;

    always_comb begin
        vptr_d = vptr_q;
        if (clr) begin
            vptr_d = '0;
        end else if (adv) begin
            vptr_d = (vptr_q == LAST) ? '0 : vptr_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vptr_q <= '0;
        end else begin
            vptr_q <= vptr_d;
        end
    end

    assign vptr = vptr_q;
endmodule

// File: rtl/asid_tlb_cam_cell.sv
module asid_tlb_cam_cell #(
    parameter int unsigned VPN_W = 30,
    parameter int unsigned ASN_W = 8
) (
    input  logic             e_valid,
    input  logic             e_glob,
    input  logic [VPN_W-1:0] e_tag,
    input  logic [ASN_W-1:0] e_asn,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    output logic             lk_match,
    output logic             fl_match
);
    // Same rule serves lookups and single-page flushes.
    always_comb begin
        lk_match = e_valid && (e_tag == lk_vpn) && (e_glob || (e_asn == lk_asn));
        fl_match = e_valid && (e_tag == fl_vpn) && (e_glob || (e_asn == fl_asn));
    end
endmodule

// File: rtl/asid_tlb_prio.sv
module asid_tlb_prio #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan downward so the lowest set bit is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned VA_W    = 43,
    parameter int unsigned ASN_W   = 8,
    parameter int unsigned PFN_W   = 27,
    parameter int unsigned PERM_W  = 8,
    localparam int unsigned PS     = asid_tlb_pkg::TLB_PAGE_SHIFT,
    localparam int unsigned VPN_W  = VA_W - PS,
    localparam int unsigned PA_W   = PFN_W + PS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm,
    output logic [PA_W-1:0]   lk_pa,
    input  logic              ins_en,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_glob,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic [PERM_W-1:0] ins_perm,
    input  logic              fl_all,
    input  logic              fl_proc,
    input  logic              fl_addr,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASN_W-1:0]  fl_asn
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [VPN_W-1:0]  tag;
        logic [ASN_W-1:0]  asn;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } tlb_state_t;

    tlb_state_t             s_d, s_q;
    asid_tlb_pkg::tlb_cmd_t cmd;
    logic [IDX_W-1:0]       vptr;
    logic [ENTRIES-1:0]     lk_match, fl_match;
    logic [ENTRIES-1:0]     valid_vec, glob_vec;
    logic                   sel_any;
    logic [IDX_W-1:0]       sel_idx;
    logic [VPN_W-1:0]       lk_vpn;

    assign lk_vpn = lk_va[VA_W-1:PS];

    asid_tlb_cmd u_cmd (
        .fl_all  (fl_all),
        .fl_proc (fl_proc),
        .fl_addr (fl_addr),
        .ins_en  (ins_en),
        .cmd     (cmd)
    );

    asid_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cmd.clear_all),
        .adv   (cmd.write),
        .vptr  (vptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        asid_tlb_cam_cell #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_cell (
            .e_valid  (s_q.ent[g].valid),
            .e_glob   (s_q.ent[g].glob),
            .e_tag    (s_q.ent[g].tag),
            .e_asn    (s_q.ent[g].asn),
            .lk_vpn   (lk_vpn),
            .lk_asn   (lk_asn),
            .fl_vpn   (fl_vpn),
            .fl_asn   (fl_asn),
            .lk_match (lk_match[g]),
            .fl_match (fl_match[g])
        );
        assign valid_vec[g] = s_q.ent[g].valid;
        assign glob_vec[g]  = s_q.ent[g].glob;
    end

    asid_tlb_prio #(.ENTRIES(ENTRIES)) u_prio (
        .req (lk_match),
        .any (sel_any),
        .idx (sel_idx)
    );

    // Lookup result comes from registered state only (R9).
    always_comb begin
        lk_hit  = sel_any;
        lk_pfn  = '0;
        lk_perm = '0;
        lk_pa   = '0;
        if (sel_any) begin
            lk_pfn  = s_q.ent[sel_idx].pfn;
            lk_perm = s_q.ent[sel_idx].perm;
            lk_pa   = {s_q.ent[sel_idx].pfn, lk_va[PS-1:0]};
        end
    end

    // Next state: flushes act on old contents, then the insert (R12).
    always_comb begin
        s_d = s_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cmd.clear_all) begin
                s_d.ent[i].valid = 1'b0;
            end else begin
                if (cmd.drop_local && !s_q.ent[i].glob) begin
                    s_d.ent[i].valid = 1'b0;
                end
                if (cmd.drop_page && fl_match[i]) begin
                    s_d.ent[i].valid = 1'b0;
                end
            end
        end
        if (cmd.write) begin
            s_d.ent[vptr].valid = 1'b1;
            s_d.ent[vptr].glob  = ins_glob;
            s_d.ent[vptr].tag   = ins_vpn;
            s_d.ent[vptr].asn   = ins_asn;
            s_d.ent[vptr].pfn   = ins_pfn;
            s_d.ent[vptr].perm  = ins_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned PFN_W   = 27,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_en,
    input logic               fl_all,
    input logic               fl_proc,
    input logic               fl_addr,
    input logic               lk_hit,
    input logic [PFN_W-1:0]   lk_pfn,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] glob_q,
    input logic [IDX_W-1:0]   vptr_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == '0));

    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q != '0));

    a_r5_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> ((valid_q == '0) && (vptr_q == '0)));

    a_r3_insert_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !fl_all) |=> valid_q[$past(vptr_q)]);

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !fl_all && (vptr_q == LAST)) |=> (vptr_q == '0));

    a_r6_local_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_proc && !fl_all && !ins_en) |=> ((valid_q & ~glob_q) == '0));

    a_r6_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_proc && !fl_all && !fl_addr && !ins_en)
        |=> ((valid_q & glob_q) == $past(valid_q & glob_q)));
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_en  (ins_en),
    .fl_all  (fl_all),
    .fl_proc (fl_proc),
    .fl_addr (fl_addr),
    .lk_hit  (lk_hit),
    .lk_pfn  (lk_pfn),
    .valid_q (valid_vec),
    .glob_q  (glob_vec),
    .vptr_q  (vptr)
);

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;
    localparam int N      = 8;
    localparam int VA_W   = 43;
    localparam int PS     = 13;
    localparam int VPN_W  = VA_W - PS;
    localparam int ASN_W  = 8;
    localparam int PFN_W  = 27;
    localparam int PERM_W = 8;
    localparam int PA_W   = PFN_W + PS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic [ASN_W-1:0]  lk_asn = '0;
    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic [PERM_W-1:0] lk_perm;
    logic [PA_W-1:0]   lk_pa;
    logic              ins_en = 1'b0, ins_glob = 1'b0;
    logic [VPN_W-1:0]  ins_vpn = '0;
    logic [ASN_W-1:0]  ins_asn = '0;
    logic [PFN_W-1:0]  ins_pfn = '0;
    logic [PERM_W-1:0] ins_perm = '0;
    logic              fl_all = 1'b0, fl_proc = 1'b0, fl_addr = 1'b0;
    logic [VPN_W-1:0]  fl_vpn = '0;
    logic [ASN_W-1:0]  fl_asn = '0;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    asid_tlb #(.ENTRIES(N), .VA_W(VA_W), .ASN_W(ASN_W), .PFN_W(PFN_W),
               .PERM_W(PERM_W)) dut_i (.*);

    // Reference model built from the requirements.
    bit                m_valid [N];
    bit                m_glob  [N];
    logic [VPN_W-1:0]  m_tag   [N];
    logic [ASN_W-1:0]  m_asn   [N];
    logic [PFN_W-1:0]  m_pfn   [N];
    logic [PERM_W-1:0] m_perm  [N];
    int                m_ptr = 0;

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
        end
    endtask

    // R1 R2 R11: expected lookup; lowest slot wins.
    task automatic check_lookup(string req);
        bit                hit = 0;
        logic [PFN_W-1:0]  pfn = '0;
        logic [PERM_W-1:0] perm = '0;
        logic [PA_W-1:0]   pa = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_valid[i] && m_tag[i] == lk_va[VA_W-1:PS] &&
                (m_glob[i] || m_asn[i] == lk_asn)) begin
                hit = 1; pfn = m_pfn[i]; perm = m_perm[i];
            end
        end
        if (hit) pa = {pfn, lk_va[PS-1:0]};
        check(req, "hit",  64'(lk_hit),  64'(hit));
        check(req, "pfn",  64'(lk_pfn),  64'(pfn));
        check(req, "perm", 64'(lk_perm), 64'(perm));
        check(req, "pa",   64'(lk_pa),   64'(pa));
    endtask

    // R3 R4 R5 R6 R7 R8 R12: model update at the edge.
    task automatic model_edge();
        if (fl_all) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
            m_ptr = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (fl_proc && !m_glob[i]) m_valid[i] = 0;
                if (fl_addr && m_tag[i] == fl_vpn && (m_glob[i] || m_asn[i] == fl_asn))
                    m_valid[i] = 0;
            end
            if (ins_en) begin
                m_valid[m_ptr] = 1; m_glob[m_ptr] = ins_glob; m_tag[m_ptr] = ins_vpn;
                m_asn[m_ptr] = ins_asn; m_pfn[m_ptr] = ins_pfn; m_perm[m_ptr] = ins_perm;
                m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            end
        end
    endtask

    // One cycle: check lookup before the edge (R9), update model, clear commands.
    task automatic step(string req);
        #1;
        check_lookup(req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ins_en = 0; fl_all = 0; fl_proc = 0; fl_addr = 0;
    endtask

    task automatic set_lk(int vpn, int asn);
        lk_va  = {VPN_W'(vpn), PS'($urandom)};
        lk_asn = ASN_W'(asn);
    endtask

    task automatic set_ins(int vpn, int asn, bit g, int pfn);
        ins_en = 1; ins_vpn = VPN_W'(vpn); ins_asn = ASN_W'(asn);
        ins_glob = g; ins_pfn = PFN_W'(pfn); ins_perm = PERM_W'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: empty after reset
        set_lk(0, 0); step("R10");
        set_lk(5, 3); step("R10");

        // R3 R4: fill all slots, then one more overwrites slot 0
        for (int i = 0; i < N; i++) begin
            set_ins(i + 1, 1, 0, 100 + i); set_lk(i + 1, 1); step("R3/R9");
        end
        set_lk(1, 1); step("R3");
        set_ins(20, 1, 0, 555); step("R4");
        set_lk(1, 1); step("R4");   // overwritten: miss
        set_lk(20, 1); step("R3");  // new one hits
        set_lk(2, 2); step("R1");   // asn mismatch

        // R8: flush-all wins over insert
        fl_all = 1; set_ins(30, 0, 0, 7); step("R8");
        set_lk(30, 0); step("R8");
        set_lk(20, 1); step("R5");

        // R11: duplicate tags, lowest slot supplies outputs
        set_ins(3, 2, 0, 1111); step("R11");
        set_ins(3, 9, 1, 2222); step("R11");
        set_lk(3, 2); step("R11");
        set_lk(3, 5); step("R11");

        // R6: flush-local keeps the global entry
        fl_proc = 1; step("R6");
        set_lk(3, 2); step("R6");

        // R7: flush-page with foreign asn hits only globals
        set_ins(4, 1, 0, 44); step("R7");
        fl_addr = 1; fl_vpn = 4; fl_asn = 2; step("R7");
        set_lk(4, 1); step("R7");
        fl_addr = 1; fl_vpn = 4; fl_asn = 1; step("R7");
        set_lk(4, 1); step("R7");

        // R12: flush-local plus insert of a private entry
        fl_proc = 1; set_ins(6, 1, 0, 66); step("R12");
        set_lk(6, 1); step("R12");

        // R9: same-cycle insert not visible yet
        set_ins(9, 0, 0, 99); set_lk(9, 0); step("R9");
        step("R9");

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            int r = $urandom_range(0, 99);
            if (r < 40) set_ins($urandom_range(0, 15), $urandom_range(0, 3),
                                ($urandom_range(0, 3) == 0), $urandom);
            if (r >= 40 && r < 52) begin
                fl_addr = 1; fl_vpn = VPN_W'($urandom_range(0, 15));
                fl_asn = ASN_W'($urandom_range(0, 3));
            end
            if (r >= 52 && r < 56) fl_proc = 1;
            if (r == 56) fl_all = 1;
            set_lk($urandom_range(0, 15), $urandom_range(0, 3));
            step("R1/R2/R7/R12");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule